// File: doc/BRIEF.md
# Data-Strobe Serial Receiver with Flush

This block recovers a serial bit stream that arrives on two lines in data/strobe form: for every bit exactly one of the two lines toggles, so the XOR of the lines flips once per bit. The receiver detects each flip, takes the data line as the bit value and packs the bits, least significant first, into 32-bit words. Each completed word is handed to a downstream receive FIFO as a one-cycle push strobe with the word.

Software watches a live count of buffered bits. At the end of a message it can request a flush. The flush emits the partial word zero-padded above the valid bits and records how many bits were valid. A level-sensitive clear holds the whole decoder in its empty state for as long as it is asserted. Both lines are expected to be synchronous to the system clock already.

Top module: `ds_rx_packer`

## Requirements
- R1: After reset, `bit_level` is 0, `word_valid` is 0, `flush_pending` is 0 and `flushed_bits` is 0.
- R2: A bit is taken on a clock edge where `ds_data ^ ds_strobe` differs from its value at the previous edge, and the bit value is `ds_data` at that edge. When both lines toggle together, or neither toggles, no bit is taken and `bit_level` stays unchanged.
- R3: The first bit after the buffer empties lands in bit 0 of the word, and each later bit lands in the next higher bit position.
- R4: The edge that takes the 32nd buffered bit pushes the word. `word_valid` is high for that one cycle with the full word on `word_data`, and `bit_level` returns to 0.
- R5: `bit_level` gives the number of buffered bits. It is updated at the same edge that takes a bit.
- R6: A `flush_start` pulse sets `flush_pending` at the next edge. The edge after that performs the flush and clears `flush_pending`. The flush pushes the buffered bits with every bit position above the valid count set to 0, and `bit_level` becomes 0.
- R7: `flushed_bits` records the number of valid bits in the flushed word. A bit taken on the flush edge itself is included in both the word and the count.
- R8: A flush with no buffered bits and no bit arriving pushes no word and sets `flushed_bits` to 0.
- R9: While `clear` is high, `bit_level`, `flushed_bits` and `flush_pending` are 0 and no word is pushed. Line activity and `flush_start` are ignored. After release, the first bit needs a new transition relative to the line state seen during clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ds_data | input | 1 | Data line of the data/strobe pair |
| ds_strobe | input | 1 | Strobe line of the data/strobe pair |
| clear | input | 1 | Level clear of all decoder state |
| flush_start | input | 1 | Request to flush the partial word |
| flush_pending | output | 1 | High from request until the flush is done |
| word_valid | output | 1 | One-cycle push strobe to the receive FIFO |
| word_data | output | 32 | Word pushed to the receive FIFO |
| bit_level | output | 6 | Bits currently buffered |
| flushed_bits | output | 6 | Valid bits in the last flushed word |

## Verification
The hardest case to reach is a bit that arrives on the very edge that performs a flush. That edge comes two cycles after the request, so the timing must line up with the pending window exactly. The stimulus holds `flush_start` for one cycle and then drives a transition in the following cycle. The expected count then includes that bit. The bench also toggles both lines at once, which keeps the XOR unchanged, and it moves the lines during clear, which shows that the transition reference is reloaded.

// File: rtl/ds_rx_packer.sv
module ds_rx_packer #(
  parameter int W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ds_data,
  input  logic                     ds_strobe,
  input  logic                     clear,
  input  logic                     flush_start,
  output logic                     flush_pending,
  output logic                     word_valid,
  output logic [W-1:0]             word_data,
  output logic [$clog2(W+1)-1:0]   bit_level,
  output logic [$clog2(W+1)-1:0]   flushed_bits
);
  localparam int LW = $clog2(W+1);

  logic          prev_x, pend_q, vld_q;
  logic [W-1:0]  buf_q, word_q;
  logic [LW-1:0] lvl_q, cnt_q;

  wire          cur_x  = ds_data ^ ds_strobe;
  wire          bit_en = cur_x != prev_x;
  wire [W-1:0]  buf_nx = bit_en ? (buf_q | (W'(ds_data) << lvl_q)) : buf_q;
  wire [LW-1:0] lvl_nx = lvl_q + LW'(bit_en);
  wire          full   = lvl_nx == LW'(W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_x <= 1'b0;
      pend_q <= 1'b0;
      vld_q  <= 1'b0;
      buf_q  <= '0;
      word_q <= '0;
      lvl_q  <= '0;
      cnt_q  <= '0;
    end else if (clear) begin
      prev_x <= cur_x;
      pend_q <= 1'b0;
      vld_q  <= 1'b0;
      buf_q  <= '0;
      lvl_q  <= '0;
      cnt_q  <= '0;
    end else begin
      prev_x <= cur_x;
      vld_q  <= 1'b0;
      if (pend_q) begin
        pend_q <= 1'b0;
        cnt_q  <= lvl_nx;
        buf_q  <= '0;
        lvl_q  <= '0;
        if (lvl_nx != '0) begin
          vld_q  <= 1'b1;
          word_q <= buf_nx;
        end
      end else begin
        if (flush_start) pend_q <= 1'b1;
        if (full) begin
          vld_q  <= 1'b1;
          word_q <= buf_nx;
          buf_q  <= '0;
          lvl_q  <= '0;
        end else begin
          buf_q <= buf_nx;
          lvl_q <= lvl_nx;
        end
      end
    end
  end

  assign flush_pending = pend_q;
  assign word_valid    = vld_q;
  assign word_data     = word_q;
  assign bit_level     = lvl_q;
  assign flushed_bits  = cnt_q;

  p_no_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !pend_q && !bit_en) |=> ($stable(bit_level) && !word_valid));
  p_level_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_level < LW'(W));
  p_push_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> (bit_level == '0));
  p_flush_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_pending && !clear) |=> !flush_pending);
  p_empty_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_pending && !clear && bit_level == '0 && !bit_en) |=> (!word_valid && flushed_bits == '0));
  p_clear_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (bit_level == '0 && !word_valid && !flush_pending && flushed_bits == '0));
endmodule

// File: tb/ds_rx_packer_bench.sv
module ds_rx_packer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ds_data = 1'b0, ds_strobe = 1'b0, clear = 1'b0, flush_start = 1'b0;
  logic flush_pending, word_valid;
  logic [31:0] word_data;
  logic [5:0] bit_level, flushed_bits;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  logic [31:0] exp_buf = '0;
  int exp_lvl = 0;

  always #2 clk = ~clk;

  ds_rx_packer u_ds_rx_packer (
    .clk(clk), .rst_n(rst_n), .ds_data(ds_data), .ds_strobe(ds_strobe),
    .clear(clear), .flush_start(flush_start), .flush_pending(flush_pending),
    .word_valid(word_valid), .word_data(word_data), .bit_level(bit_level),
    .flushed_bits(flushed_bits));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    ds_strobe = b ^ ~(ds_data ^ ds_strobe);
    ds_data   = b;
    exp_buf[exp_lvl] = b;
    exp_lvl++;
    if (exp_lvl == 32) begin
      exp_q.push_back(exp_buf);
      exp_buf = '0;
      exp_lvl = 0;
    end
  endtask

  task automatic send_word(input logic [31:0] w, input int n);
    for (int i = 0; i < n; i++) send_bit(w[i]);
  endtask

  always @(negedge clk) begin
    if (rst_n && word_valid) begin
      if (exp_q.size() == 0) chk("R4 unexpected push", word_data, 32'hxxxxxxxx);
      else chk("R3/R4/R6 pushed word", word_data, exp_q.pop_front());
    end
  end

  initial begin
    #(4 * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 level", 32'(bit_level), 0);
    chk("R1 valid", 32'(word_valid), 0);
    chk("R1 pending", 32'(flush_pending), 0);
    chk("R1 flushed", 32'(flushed_bits), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R5: level counts bits, updated at the capturing edge
    send_word(32'h0000_0055, 7);
    @(negedge clk);
    chk("R5 level after 7", 32'(bit_level), 7);
    // R2: both lines toggle together -> no bit
    ds_data = ~ds_data; ds_strobe = ~ds_strobe;
    repeat (3) @(negedge clk);
    chk("R2 no bit on double toggle", 32'(bit_level), 7);
    // R3/R4: finish the word, pattern packs LSB first
    exp_q.delete(); exp_buf = 32'h0000_0055 & 32'h7F; exp_lvl = 7;
    for (int i = 7; i < 32; i++) send_bit(1'(32'hA5C3_1E55 >> i));
    @(negedge clk);
    chk("R4 level back to 0", 32'(bit_level), 0);
    send_word(32'hFFFF_0001, 32);
    @(negedge clk);
    chk("R4 second word level", 32'(bit_level), 0);

    // R6/R7: flush of a partial word
    send_word(32'h0000_002D, 6);
    exp_q.push_back(exp_buf); exp_buf = '0; exp_lvl = 0;
    @(negedge clk); flush_start = 1'b1;
    @(negedge clk); flush_start = 1'b0;
    chk("R6 pending set", 32'(flush_pending), 1);
    @(negedge clk);
    chk("R6 pending cleared", 32'(flush_pending), 0);
    chk("R7 flushed count", 32'(flushed_bits), 6);
    chk("R6 level after flush", 32'(bit_level), 0);

    // R7: bit arriving on the flush edge is included
    send_word(32'h0000_0003, 3);
    @(negedge clk); flush_start = 1'b1;
    @(negedge clk); flush_start = 1'b0;
    exp_buf[3] = 1'b1; exp_q.push_back(exp_buf); exp_buf = '0; exp_lvl = 0;
    ds_strobe = 1'b1 ^ ~(ds_data ^ ds_strobe); ds_data = 1'b1;
    @(negedge clk);
    chk("R7 count with edge bit", 32'(flushed_bits), 4);
    chk("R7 level after", 32'(bit_level), 0);

    // R8: empty flush
    @(negedge clk); flush_start = 1'b1;
    @(negedge clk); flush_start = 1'b0;
    @(negedge clk);
    chk("R8 empty flush count", 32'(flushed_bits), 0);
    chk("R8 empty flush pending", 32'(flush_pending), 0);

    // R9: clear
    send_word(32'h0000_0005, 5);
    @(negedge clk); clear = 1'b1; flush_start = 1'b1;
    @(negedge clk); flush_start = 1'b0;
    chk("R9 level in clear", 32'(bit_level), 0);
    chk("R9 pending in clear", 32'(flush_pending), 0);
    ds_data = ~ds_data;
    @(negedge clk);
    ds_strobe = ~ds_strobe; ds_data = ~ds_data;
    @(negedge clk);
    chk("R9 line activity ignored", 32'(bit_level), 0);
    clear = 1'b0; exp_buf = '0; exp_lvl = 0;
    repeat (3) @(negedge clk);
    chk("R9 no spurious bit", 32'(bit_level), 0);
    chk("R9 flush ignored", 32'(flush_pending), 0);
    send_word(32'h0000_0001, 2);
    @(negedge clk);
    chk("R9 receives after release", 32'(bit_level), 2);

    repeat (2) @(negedge clk);
    chk("R4 all words seen", 32'(exp_q.size()), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule